// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Validation

This block turns an asynchronous serial line into characters. A two-flop synchroniser brings the line into the clock domain. A one-cycle enable marks each tick of a clock running at sixteen times the bit rate. Hunting starts when the receiver sees a falling edge on the line. It looks at the line again at the middle of the start bit, and a start that has already returned high is thrown away. After a valid start, it samples the data bits, the optional parity bit and a single stop bit at their bit centres, least significant bit first.

Each character is delivered as a one-cycle strobe. The strobe carries the data byte and three flags: parity error, framing error and break. The data and flags are held until the next character. A line held low for a whole frame is reported as a break. A framing error on a nonzero character, with the line still low, is treated as the start of the next character.

Software or a surrounding controller sets the character format on static inputs. These are the data length (5 to 8 bits) and whether parity is used, with even or odd sense. An enable input turns reception on and off.

Top module: `async_rx`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0x00, and out_perr, out_ferr and out_brk are all 0.
- R2: The receiver looks at the line again 8 ticks after the tick on which it saw a high-to-low change. If the line is high at that point, no character is produced and hunting restarts. A low pulse shorter than that produces nothing.
- R3: Data bits are sampled every 16 ticks at the bit centre, least significant bit first. cfg_len selects the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Any out_data bit above the selected length is 0.
- R4: When cfg_par_en is 1, one parity bit follows the data. cfg_par_odd = 0 selects even parity and 1 selects odd. out_perr is 1 when the data bits and the parity bit together have a ones count that does not match the selected sense. out_perr is 0 when parity is off.
- R5: Only one stop bit is checked. After a high stop sample, the character is delivered with out_ferr = 0 and hunting restarts at once, so frames sent back to back with no idle time are all received.
- R6: A low stop sample sets out_ferr = 1 and still delivers the data bits.
- R7: After a low stop sample on a nonzero character, the receiver checks the line 8 ticks later. If the line is still low, that tick is taken as a new start edge, and the next character is received without a high-to-low change.
- R8: If every sample of a frame is low, including parity and stop, the receiver delivers out_data = 0x00 with out_brk = 1 and out_ferr = 1. It then produces no further character while the line stays low.
- R9: A break ends only when the line is high on two consecutive ticks. A single high tick followed by a low line produces no character.
- R10: out_valid is a one-cycle pulse. out_data and the flags are presented in the same cycle and held until the next pulse.
- R11: While rx_en is 0, no character is produced and any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length: 00=5, 01=6, 10=7, 11=8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| out_valid | output | 1 | One-cycle character strobe |
| out_data | output | 8 | Received character, unused upper bits zero |
| out_perr | output | 1 | Parity error for the character |
| out_ferr | output | 1 | Framing error (stop bit sampled low) |
| out_brk | output | 1 | Break received |

## Verification
The hardest path to reach from the ports is the recovery after a framing error. The line has to stay low across the half-bit boundary after the stop sample, and the next character must follow with no rising edge the receiver could lock onto. The bench moves the line only on tick boundaries. It sends a frame whose stop window is low, holds the line low for one more bit time as the next start bit, and chooses the next data so that any misaligned lock would give a different byte. The break exit is reached the same way: a high pulse exactly one tick wide, followed by another full low frame, would produce a second break character if that single tick were taken as the end of the break.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
    typedef enum logic [2:0] {
        S_HUNT,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_FWAIT,
        S_BRK
    } rx_state_e;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/async_rx_parity.sv
module async_rx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          pbit,
    input  logic          odd,
    output logic          err
);
    always_comb begin
        err = (^data) ^ pbit ^ odd;
    end
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
    import async_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          rx_s,
    input  logic [1:0]    cfg_len,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          o_valid,
    output logic [DW-1:0] o_data,
    output logic          o_perr,
    output logic          o_ferr,
    output logic          o_brk
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bidx;
        logic          last;
        logic          allz;
        logic          pbit;
        logic          hc;
        logic [DW-1:0] shd;
        logic          ov;
        logic [DW-1:0] od;
        logic          ope;
        logic          ofe;
        logic          obk;
    } frame_t;

    frame_t st_d, st_q;
    logic [BW-1:0] last_idx;
    logic          perr_w;

    async_rx_parity #(.DW(DW)) u_par (
        .data (st_q.shd),
        .pbit (st_q.pbit),
        .odd  (par_odd),
        .err  (perr_w)
    );

    always_comb begin
        last_idx = BW'(DW - 4) + BW'(cfg_len);
        st_d     = st_q;
        st_d.ov  = 1'b0;
        if (!en) begin
            st_d.st   = S_HUNT;
            st_d.cnt  = '0;
            st_d.last = rx_s;
        end else if (tick) begin
            case (st_q.st)
                S_HUNT: begin
                    st_d.last = rx_s;
                    if (st_q.last && !rx_s) begin
                        st_d.st  = S_START;
                        st_d.cnt = '0;
                    end
                end
                S_START: begin
                    if (st_q.cnt == HALF_M1) begin
                        st_d.cnt = '0;
                        if (rx_s) begin
                            st_d.st   = S_HUNT;
                            st_d.last = 1'b1;
                        end else begin
                            st_d.st   = S_DATA;
                            st_d.bidx = '0;
                            st_d.shd  = '0;
                            st_d.allz = 1'b1;
                            st_d.pbit = 1'b0;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (st_q.cnt == FULL_M1) begin
                        st_d.cnt            = '0;
                        st_d.shd[st_q.bidx] = rx_s;
                        st_d.allz           = st_q.allz & ~rx_s;
                        st_d.bidx           = st_q.bidx + 1'b1;
                        if (st_q.bidx == last_idx)
                            st_d.st = par_en ? S_PAR : S_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (st_q.cnt == FULL_M1) begin
                        st_d.cnt  = '0;
                        st_d.pbit = rx_s;
                        st_d.allz = st_q.allz & ~rx_s;
                        st_d.st   = S_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (st_q.cnt == FULL_M1) begin
                        st_d.cnt = '0;
                        st_d.ov  = 1'b1;
                        st_d.od  = st_q.shd;
                        st_d.ope = par_en & perr_w;
                        st_d.ofe = ~rx_s;
                        st_d.obk = ~rx_s & st_q.allz;
                        st_d.hc  = 1'b0;
                        if (rx_s) begin
                            st_d.st   = S_HUNT;
                            st_d.last = 1'b1;
                        end else if (st_q.allz) begin
                            st_d.st = S_BRK;
                        end else if (|st_q.shd) begin
                            st_d.st = S_FWAIT;
                        end else begin
                            st_d.st   = S_HUNT;
                            st_d.last = 1'b0;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                S_FWAIT: begin
                    if (st_q.cnt == HALF_M1) begin
                        st_d.cnt = '0;
                        if (!rx_s) begin
                            st_d.st = S_START;
                        end else begin
                            st_d.st   = S_HUNT;
                            st_d.last = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                S_BRK: begin
                    if (rx_s) begin
                        if (st_q.hc) begin
                            st_d.st   = S_HUNT;
                            st_d.last = 1'b1;
                            st_d.hc   = 1'b0;
                        end else begin
                            st_d.hc = 1'b1;
                        end
                    end else begin
                        st_d.hc = 1'b0;
                    end
                end
                default: st_d.st = S_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= S_HUNT;
            st_q.last <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.ov;
    assign o_data  = st_q.od;
    assign o_perr  = st_q.ope;
    assign o_ferr  = st_q.ofe;
    assign o_brk   = st_q.obk;

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |=> !o_valid);

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> ((32'(o_data) >> (32'(DW - 3) + 32'(cfg_len))) == 32'd0));

    // R8
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_brk) |-> (o_data == '0 && o_ferr));

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !o_valid);

    // R2
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && st_q.st == S_START && st_q.cnt == HALF_M1 && rx_s)
        |=> (st_q.st == S_HUNT));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
    parameter int OSR       = 16,
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rx_en,
    input  logic          rxd,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_perr,
    output logic          out_ferr,
    output logic          out_brk
);
    logic rx_s;

    async_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    async_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .en      (rx_en),
        .rx_s    (rx_s),
        .cfg_len (cfg_len),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .o_valid (out_valid),
        .o_data  (out_data),
        .o_perr  (out_perr),
        .o_ferr  (out_ferr),
        .o_brk   (out_brk)
    );
endmodule

// File: tb/async_rx_tb.sv
module async_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_en = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_perr, out_ferr, out_brk;

    int checks = 0;
    int errors = 0;
    int got_n = 0;
    logic [10:0] got [8];
    logic [1:0] tdiv = 2'd0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
        if (out_valid) begin
            got[got_n % 8] <= {out_brk, out_ferr, out_perr, out_data};
            got_n          <= got_n + 1;
        end
    end

    async_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .out_valid(out_valid), .out_data(out_data), .out_perr(out_perr),
        .out_ferr(out_ferr), .out_brk(out_brk)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic put_bit(input logic b, input int len);
        rxd = b;
        wait_ticks(len);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit pe, input logic pb, input logic stop);
        put_bit(1'b0, 16);
        for (int i = 0; i < nb; i++) put_bit(d[i], 16);
        if (pe) put_bit(pb, 16);
        put_bit(stop, 16);
    endtask

    task automatic expect_count(input int mark, input int n, input string req);
        chk(got_n - mark == n, req, 32'(got_n - mark), 32'(n));
    endtask

    task automatic expect_char(input int idx, input logic [10:0] exp, input string req);
        chk(got[idx % 8] == exp, req, 32'(got[idx % 8]), 32'(exp));
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1 valid", 32'(out_valid), 0);
        chk({out_brk, out_ferr, out_perr, out_data} == 11'h0, "R1 data/flags",
            32'({out_brk, out_ferr, out_perr, out_data}), 0);
    endtask

    task automatic t_basic();
        int m = got_n;
        cfg_len = 2'b11; cfg_par_en = 1'b0;
        send(8'hA5, 8, 0, 0, 1); put_bit(1, 32);
        send(8'h3C, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 2, "R3 basic count");
        expect_char(m, 11'h0A5, "R3 lsb-first A5");
        expect_char(m + 1, 11'h03C, "R3 lsb-first 3C");
    endtask

    task automatic t_short();
        int m = got_n;
        cfg_len = 2'b00;
        send(8'hF6, 5, 0, 0, 1); put_bit(1, 32);
        cfg_len = 2'b10;
        send(8'hDA, 7, 0, 0, 1); put_bit(1, 32);
        cfg_len = 2'b11;
        expect_count(m, 2, "R3 short count");
        expect_char(m, 11'h016, "R3 5-bit upper zero");
        expect_char(m + 1, 11'h05A, "R3 7-bit upper zero");
    endtask

    task automatic t_parity();
        int m = got_n;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'hA5, 8, 1, 0, 1); put_bit(1, 32);
        send(8'hA5, 8, 1, 1, 1); put_bit(1, 32);
        cfg_par_odd = 1'b1;
        send(8'h07, 8, 1, 0, 1); put_bit(1, 32);
        send(8'h07, 8, 1, 1, 1); put_bit(1, 32);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        expect_count(m, 4, "R4 parity count");
        expect_char(m, 11'h0A5, "R4 even good");
        expect_char(m + 1, 11'h1A5, "R4 even bad");
        expect_char(m + 2, 11'h007, "R4 odd good");
        expect_char(m + 3, 11'h107, "R4 odd bad");
    endtask

    task automatic t_false_start();
        int m = got_n;
        put_bit(0, 6); put_bit(1, 200);
        expect_count(m, 0, "R2 false start rejected");
        send(8'h81, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 1, "R2 hunt resumes");
        expect_char(m, 11'h081, "R2 char after false start");
    endtask

    task automatic t_back_to_back();
        int m = got_n;
        send(8'h12, 8, 0, 0, 1);
        send(8'h34, 8, 0, 0, 1);
        send(8'hFE, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 3, "R5 back-to-back count");
        expect_char(m + 1, 11'h034, "R5 second frame");
        expect_char(m + 2, 11'h0FE, "R5 third frame");
    endtask

    task automatic t_ferr();
        int m = got_n;
        put_bit(0, 16);
        for (int i = 0; i < 8; i++) put_bit(8'h5A >> i, 16);
        put_bit(0, 12); put_bit(1, 200);
        expect_count(m, 1, "R6 framing count");
        expect_char(m, 11'h25A, "R6 framing flag");
    endtask

    task automatic t_resync();
        int m = got_n;
        send(8'h5A, 8, 0, 0, 0);
        send(8'h55, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 2, "R7 resync count");
        expect_char(m, 11'h25A, "R7 first framing");
        expect_char(m + 1, 11'h055, "R7 resynced char");
    endtask

    task automatic t_break();
        int m = got_n;
        put_bit(0, 224);
        expect_count(m, 1, "R8 break count");
        expect_char(m, 11'h600, "R8 break char");
        put_bit(1, 1); put_bit(0, 224);
        expect_count(m, 1, "R9 single high tick ignored");
        put_bit(1, 40);
        send(8'hC3, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 2, "R9 break exit");
        expect_char(m + 1, 11'h0C3, "R9 char after break");
    endtask

    task automatic t_disable();
        int m = got_n;
        rx_en = 1'b0;
        send(8'hA5, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 0, "R11 disabled");
        rx_en = 1'b1;
        put_bit(0, 16); put_bit(1, 40);
        rx_en = 1'b0; put_bit(1, 4); rx_en = 1'b1;
        put_bit(1, 200);
        expect_count(m, 0, "R11 frame dropped on disable");
        send(8'h77, 8, 0, 0, 1); put_bit(1, 32);
        expect_count(m, 1, "R11 re-enabled");
        expect_char(m, 11'h077, "R11 char after enable");
    endtask

    task automatic t_hold();
        int m = got_n;
        send(8'h9C, 8, 0, 0, 1); put_bit(1, 40);
        expect_count(m, 1, "R10 single strobe");
        chk(out_valid == 1'b0 && out_data == 8'h9C, "R10 data held",
            32'({out_valid, out_data}), 32'h09C);
    endtask

    bit done = 0;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        put_bit(1, 4);
        t_reset();
        t_basic();
        t_short();
        t_parity();
        t_false_start();
        t_back_to_back();
        t_ferr();
        t_resync();
        t_break();
        t_disable();
        t_hold();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule